// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM that holds 16-bit words at 6-bit addresses. A host pulses `start_i` with an operation code, an address and, for writes, a data word. The block then frames an 11-bit command, shifts data to or from the memory, and releases the bus. Every pin change is spaced by a settle interval of `SETTLE_CYCLES` system clocks. After a write or an erase, it deselects the memory, selects it again and polls the memory's data line until the memory reports ready or a poll budget runs out.

The command word is two zero bits, then a start bit and two operation bits, then the 6-bit address, sent MSB first. The enable/disable operation carries no address: its address field is all ones for enable and all zeros for disable.

The controller is one state machine. Its states are IDLE, SELECT, CMD_LO, CMD_HI, RD_LO, RD_HI, WR_LO, WR_HI, DESEL, POLL and FINISH, and each state except IDLE lasts one settle interval. The transitions are:
- IDLE to SELECT on an accepted start.
- SELECT to CMD_LO.
- CMD_LO to CMD_HI.
- CMD_HI back to CMD_LO while command bits remain. After the last command bit, CMD_HI goes to RD_LO for a read, to WR_LO for a write, to DESEL for an erase and to FINISH for enable/disable.
- RD_LO to RD_HI. RD_HI goes back to RD_LO while bits remain, and to FINISH after the last bit.
- WR_LO to WR_HI. WR_HI goes back to WR_LO while bits remain, and to DESEL after the last bit.
- DESEL to POLL.
- POLL to FINISH on a ready sample or when the poll budget is spent.
- FINISH to IDLE, pulsing done.

Top module: `uwire_eeprom_master`

## Requirements
- R1: The command word is 11 bits, sent MSB first on `mw_dout_o`: two zero bits, then a 3-bit opcode, then the 6-bit address. `op_i` selects the operation: 0 is read (opcode 110), 1 is write (opcode 101), 2 is erase (opcode 111) and 3 is enable/disable (opcode 100).
- R2: Enable/disable (`op_i`=3) sends opcode 100 with address field 111111 when `wr_en_i`=1 and 000000 when `wr_en_i`=0. It ends right after the command, with no data phase and no poll.
- R3: For each bit sent, data out is set while the serial clock is low, then the clock rises with data held. Data out never changes while the clock is high. Each clock-high phase lasts exactly `SETTLE_CYCLES` system clocks.
- R4: A read gives 16 more clock pulses after the command and samples `mw_din_i` at the end of each high phase, MSB first. The result appears on `rdata_o` with done and stays there through later non-read operations.
- R5: A write sends the 16 bits of `wdata_i`, MSB first, right after the command, in the same select window.
- R6: After the write data, or after an erase command, chip select drops for one settle interval and is then raised again. `mw_din_i` is then sampled once per settle interval. The first high sample ends the operation with `timeout_o`=0.
- R7: If `MAX_POLLS` samples in a row read low, the operation ends with `timeout_o`=1. That poll window lasts `MAX_POLLS`*`SETTLE_CYCLES` clocks. `timeout_o` is cleared when the next operation is accepted.
- R8: Chip select is low when every operation ends. `done_o` is high for exactly one cycle per operation, and `busy_o` is high from the cycle after an accepted start until done.
- R9: A start pulse that arrives while `busy_o` is high is ignored: the operation in progress keeps its frame, its result and its single done pulse.
- R10: After reset, chip select, serial clock and data out are low and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 2 | 0 read, 1 write, 2 erase, 3 enable/disable |
| wr_en_i | input | 1 | For op 3: 1 enables writes, 0 disables them |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Word to write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last word read |
| timeout_o | output | 1 | Ready poll exhausted on the last write/erase |
| mw_cs_o | output | 1 | Chip select, active high |
| mw_clk_o | output | 1 | Serial clock, idles low |
| mw_dout_o | output | 1 | Serial data to the memory |
| mw_din_i | input | 1 | Serial data from the memory |

## Verification
The hardest condition to reach is the end of the poll budget, because a working memory answers ready within a few samples. The bench models the memory and holds its data line low for a chosen number of clocks after chip select rises again. It uses a very large hold to force the timeout, measures the length of the poll window, and then runs an erase to confirm that the flag clears. A second hard case is a start pulse that lands in the middle of a read frame. This is produced by pulsing start a few settle intervals into the read and then checking the captured frame bit by bit.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_WREN  = 2'd3
    } uw_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SELECT,
        S_CMD_LO,
        S_CMD_HI,
        S_RD_LO,
        S_RD_HI,
        S_WR_LO,
        S_WR_HI,
        S_DESEL,
        S_POLL,
        S_FINISH
    } uw_state_e;

    localparam int unsigned LEAD_ZEROS = 2;
    localparam int unsigned OPC_W      = 3;

    function automatic logic [OPC_W-1:0] opcode_of(uw_op_e op);
        logic [OPC_W-1:0] oc;
        unique case (op)
            OP_READ:  oc = 3'b110;
            OP_WRITE: oc = 3'b101;
            OP_ERASE: oc = 3'b111;
            default:  oc = 3'b100;
        endcase
        return oc;
    endfunction

endpackage

// File: rtl/uwire_pace.sv
module uwire_pace #(
    parameter int unsigned SETTLE_CYCLES = 12500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

endmodule

// File: rtl/uwire_poll_ctr.sv
module uwire_poll_ctr #(
    parameter int unsigned MAX_POLLS = 10000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic inc_i,
    output logic expire_o
);
    localparam int unsigned PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [PW-1:0] LAST = PW'(MAX_POLLS - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = (cnt_q == LAST);

    a_r7_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

endmodule

// File: rtl/uwire_shifter.sv
module uwire_shifter
    import uwire_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  uw_op_e            op_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cmd_shift_i,
    input  logic              data_shift_i,
    input  logic              data_in_i,
    output logic              cmd_bit_o,
    output logic              data_bit_o,
    output logic              last_bit_o,
    output logic [DATA_W-1:0] data_word_o
);
    localparam int unsigned CMD_W = LEAD_ZEROS + OPC_W + ADDR_W;
    localparam int unsigned MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int unsigned CNT_W = $clog2(MAXB);

    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_field;
    logic [CMD_W-1:0]  cmd_word;

    always_comb begin
        if (op_i == OP_WREN) begin
            addr_field = {ADDR_W{wr_en_i}};
        end else begin
            addr_field = addr_i;
        end
        cmd_word = {{LEAD_ZEROS{1'b0}}, opcode_of(op_i), addr_field};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q  <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            cmd_q  <= cmd_word;
            data_q <= wdata_i;
            cnt_q  <= CNT_W'(CMD_W - 1);
        end else if (cmd_shift_i) begin
            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
            if (cnt_q == '0) begin
                cnt_q <= CNT_W'(DATA_W - 1);
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (data_shift_i) begin
            data_q <= {data_q[DATA_W-2:0], data_in_i};
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cmd_bit_o   = cmd_q[CMD_W-1];
    assign data_bit_o  = data_q[DATA_W-1];
    assign last_bit_o  = (cnt_q == '0);
    assign data_word_o = data_q;

    a_r1_no_double_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_shift_i && data_shift_i));

endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uwire_pkg::*;
#(
    parameter int unsigned ADDR_W        = 6,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned SETTLE_CYCLES = 12500,
    parameter int unsigned MAX_POLLS     = 10000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              timeout_o,
    output logic              mw_cs_o,
    output logic              mw_clk_o,
    output logic              mw_dout_o,
    input  logic              mw_din_i
);
    uw_state_e state_q, state_d;
    uw_op_e    op_q;
    logic      accept;
    logic      tick;
    logic      run;
    logic      cmd_bit, data_bit, last_bit;
    logic      cmd_shift, data_shift;
    logic      poll_clear, poll_inc, poll_expire;
    logic [DATA_W-1:0] data_word;
    logic              done_q, timeout_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept = (state_q == S_IDLE) && start_i;
    assign run    = (state_q != S_IDLE);

    uwire_pace #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pace (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .tick_o (tick)
    );

    uwire_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (accept),
        .op_i         (uw_op_e'(op_i)),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .cmd_shift_i  (cmd_shift),
        .data_shift_i (data_shift),
        .data_in_i    (mw_din_i),
        .cmd_bit_o    (cmd_bit),
        .data_bit_o   (data_bit),
        .last_bit_o   (last_bit),
        .data_word_o  (data_word)
    );

    uwire_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (poll_clear),
        .inc_i    (poll_inc),
        .expire_o (poll_expire)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SELECT;
            S_SELECT: if (tick) state_d = S_CMD_LO;
            S_CMD_LO: if (tick) state_d = S_CMD_HI;
            S_CMD_HI: begin
                if (tick) begin
                    if (!last_bit) begin
                        state_d = S_CMD_LO;
                    end else begin
                        unique case (op_q)
                            OP_READ:  state_d = S_RD_LO;
                            OP_WRITE: state_d = S_WR_LO;
                            OP_ERASE: state_d = S_DESEL;
                            default:  state_d = S_FINISH;
                        endcase
                    end
                end
            end
            S_RD_LO:  if (tick) state_d = S_RD_HI;
            S_RD_HI:  if (tick) state_d = last_bit ? S_FINISH : S_RD_LO;
            S_WR_LO:  if (tick) state_d = S_WR_HI;
            S_WR_HI:  if (tick) state_d = last_bit ? S_DESEL : S_WR_LO;
            S_DESEL:  if (tick) state_d = S_POLL;
            S_POLL:   if (tick && (mw_din_i || poll_expire)) state_d = S_FINISH;
            S_FINISH: if (tick) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pin and datapath control outputs
    always_comb begin
        mw_cs_o    = 1'b0;
        mw_clk_o   = 1'b0;
        mw_dout_o  = 1'b0;
        cmd_shift  = 1'b0;
        data_shift = 1'b0;
        poll_clear = 1'b0;
        poll_inc   = 1'b0;
        unique case (state_q)
            S_IDLE:   poll_clear = 1'b1;
            S_SELECT: mw_cs_o = 1'b1;
            S_CMD_LO: begin
                mw_cs_o   = 1'b1;
                mw_dout_o = cmd_bit;
            end
            S_CMD_HI: begin
                mw_cs_o   = 1'b1;
                mw_clk_o  = 1'b1;
                mw_dout_o = cmd_bit;
                cmd_shift = tick;
            end
            S_RD_LO:  mw_cs_o = 1'b1;
            S_RD_HI: begin
                mw_cs_o    = 1'b1;
                mw_clk_o   = 1'b1;
                data_shift = tick;
            end
            S_WR_LO: begin
                mw_cs_o   = 1'b1;
                mw_dout_o = data_bit;
            end
            S_WR_HI: begin
                mw_cs_o    = 1'b1;
                mw_clk_o   = 1'b1;
                mw_dout_o  = data_bit;
                data_shift = tick;
            end
            S_DESEL:  poll_clear = 1'b1;
            S_POLL: begin
                mw_cs_o  = 1'b1;
                poll_inc = tick && !mw_din_i;
            end
            S_FINISH: ;
            default: ;
        endcase
    end

    // operation result registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q      <= OP_READ;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= (state_q == S_FINISH) && tick;
            if (accept) begin
                op_q      <= uw_op_e'(op_i);
                timeout_q <= 1'b0;
            end
            if (state_q == S_POLL && tick && !mw_din_i && poll_expire) begin
                timeout_q <= 1'b1;
            end
            if (state_q == S_FINISH && tick && op_q == OP_READ) begin
                rdata_q <= data_word;
            end
        end
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign rdata_o   = rdata_q;
    assign timeout_o = timeout_q;

    a_r3_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mw_clk_o && $past(mw_clk_o)) |-> $stable(mw_dout_o));

    a_r3_edge_paced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mw_clk_o) |-> $past(tick));

    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!mw_cs_o && !busy_o));

    a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(op_q));

    a_r7_timeout_from_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> $past(state_q == S_POLL));

    a_r10_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!mw_cs_o && !mw_clk_o && !mw_dout_o));

endmodule

// File: tb/test_uwire_eeprom_master.sv
module test_uwire_eeprom_master;
    localparam int SETTLE = 4;
    localparam int POLLS  = 8;
    localparam int NVEC   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        wen = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, tmo, cs, sk, dout;
    logic [15:0] rdata;
    logic        mdi = 1'b0;

    int errors = 0;
    int checks = 0;

    uwire_eeprom_master #(
        .ADDR_W(6), .DATA_W(16), .SETTLE_CYCLES(SETTLE), .MAX_POLLS(POLLS)
    ) i_uwire_eeprom_master (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wr_en_i(wen),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .timeout_o(tmo), .mw_cs_o(cs), .mw_clk_o(sk),
        .mw_dout_o(dout), .mw_din_i(mdi)
    );

    always #4 clk = ~clk;

    // memory model state
    logic [31:0] cap;
    int nbits, win, wlen, pc, hilen, viol, ndone;
    logic m_read;
    logic [15:0] m_rd;
    int m_busy;
    logic prev_cs = 1'b0, prev_sk = 1'b0, prev_do = 1'b0;

    always @(negedge clk) begin
        if (cs && !prev_cs) begin
            win++;
            wlen = 0;
            pc = 0;
        end
        if (cs) wlen++;
        if (cs && sk && !prev_sk) begin
            cap = {cap[30:0], dout};
            nbits++;
            if (m_read && nbits >= 12 && nbits <= 27) mdi = m_rd[27-nbits];
        end
        if (cs && win == 2) begin
            pc++;
            mdi = (pc > m_busy);
        end
        if (sk) begin
            hilen++;
            if (prev_sk && dout != prev_do) viol++;
        end else if (prev_sk) begin
            if (hilen != SETTLE) viol++;
            hilen = 0;
        end
        if (done) ndone++;
        prev_cs = cs;
        prev_sk = sk;
        prev_do = dout;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input logic [1:0] o, input logic e,
                                             input logic [5:0] a, input logic [15:0] w);
        logic [2:0] oc;
        logic [5:0] af;
        case (o)
            2'd0: oc = 3'b110;
            2'd1: oc = 3'b101;
            2'd2: oc = 3'b111;
            default: oc = 3'b100;
        endcase
        af = (o == 2'd3) ? {6{e}} : a;
        if (o == 2'd0) return {5'b0, oc, af, 16'h0000};
        if (o == 2'd1) return {5'b0, oc, af, w};
        return {21'b0, oc, af};
    endfunction

    task automatic run_op(input logic [1:0] o, input logic e, input logic [5:0] a,
                          input logic [15:0] w, input logic [15:0] rd, input int bz,
                          input int intrude);
        int n;
        cap = '0; nbits = 0; win = 0; wlen = 0; pc = 0; hilen = 0; viol = 0; ndone = 0;
        m_read = (o == 2'd0); m_rd = rd; m_busy = bz; mdi = 1'b0;
        @(negedge clk);
        op = o; wen = e; addr = a; wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude > 0) begin
            repeat (intrude) @(negedge clk);
            chk(busy === 1'b1, "R8", "busy during op", {31'b0, busy}, 1);
            op = 2'd1; addr = 6'h3F; wdata = 16'hDEAD; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R8", "watchdog", n, 0);
        repeat (3) @(negedge clk);
        m_read = 1'b0; mdi = 1'b0;
    endtask

    // vector: op, en, addr, wdata, model read data, model busy clocks
    localparam logic [48:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 6'h00, 16'h0000, 16'hA5C3, 8'd0},
        {2'd1, 1'b0, 6'h15, 16'h8001, 16'h0000, 8'd10},
        {2'd0, 1'b0, 6'h3F, 16'h0000, 16'h0001, 8'd0},
        {2'd1, 1'b0, 6'h2A, 16'hFFFF, 16'h0000, 8'd3},
        {2'd2, 1'b0, 6'h07, 16'h0000, 16'h0000, 8'd5},
        {2'd3, 1'b1, 6'h12, 16'h0000, 16'h0000, 8'd0},
        {2'd3, 1'b0, 6'h2D, 16'h0000, 16'h0000, 8'd0},
        {2'd0, 1'b0, 6'h21, 16'h0000, 16'h8000, 8'd0}
    };

    initial begin
        logic [15:0] last_rd;
        logic [31:0] ef;
        int eb, ew;
        last_rd = 16'h0000;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!cs && !sk && !dout, "R10", "pins at reset", {29'b0, cs, sk, dout}, 0);
        chk(!busy && !done, "R10", "busy/done at reset", {30'b0, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cs && !sk && !dout && !busy, "R10", "idle after reset",
            {28'b0, cs, sk, dout, busy}, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] o;
            logic e;
            logic [5:0] a;
            logic [15:0] w, rd;
            int bz;
            {o, e, a, w, rd} = VEC[v][48:8];
            bz = int'(VEC[v][7:0]);
            run_op(o, e, a, w, rd, bz, 0);
            ef = frame_of(o, e, a, w);
            eb = (o == 2'd0 || o == 2'd1) ? 27 : 11;
            ew = (o == 2'd1 || o == 2'd2) ? 2 : 1;
            chk(cap == ef, (o == 2'd3) ? "R2" : (o == 2'd1 ? "R5" : "R1"), "frame", cap, ef);
            chk(nbits == eb, "R1", "clock count", nbits, eb);
            chk(win == ew, "R6", "select windows", win, ew);
            chk(viol == 0, "R3", "bit timing", viol, 0);
            chk(ndone == 1 && !cs, "R8", "single done, deselected", ndone, 1);
            if (o == 2'd0) last_rd = rd;
            chk(rdata == last_rd, "R4", "read data held", rdata, last_rd);
            chk(tmo == 1'b0, "R6", "no timeout when ready", tmo, 0);
        end

        // R7 timeout: memory never ready
        run_op(2'd1, 1'b0, 6'h01, 16'h1234, 16'h0000, 100000, 0);
        chk(tmo == 1'b1, "R7", "timeout flag", tmo, 1);
        chk(wlen == POLLS * SETTLE, "R7", "poll window", wlen, POLLS * SETTLE);
        chk(win == 2 && !cs, "R7", "ends deselected", win, 2);
        run_op(2'd2, 1'b0, 6'h02, 16'h0000, 16'h0000, 0, 0);
        chk(tmo == 1'b0, "R7", "flag cleared by next op", tmo, 0);

        // R9 start while busy
        run_op(2'd0, 1'b0, 6'h0A, 16'h0000, 16'h1234, 0, 5 * SETTLE);
        ef = frame_of(2'd0, 1'b0, 6'h0A, 16'h0);
        chk(cap == ef, "R9", "frame unchanged", cap, ef);
        chk(ndone == 1, "R9", "one done", ndone, 1);
        chk(rdata == 16'h1234, "R9", "read result", rdata, 16'h1234);
        chk(win == 1 && !busy, "R9", "no second op", win, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule